// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a first-in first-out buffer between two clock domains. A producer pushes words on its own write clock, a consumer pulls them on an independent read clock, and four active-low status flags tell each side when it may act. Two flags belong to the write domain: input-ready (high while a slot is free) and almost-full. Two belong to the read domain: output-ready (high while a word can be taken) and almost-empty. Each flag changes only on an edge of its own clock.

A static mode input selects how the read port behaves. In standard mode, a read strobe accepted while output-ready is high copies the next word into the output register on that edge. In first-word-fall-through mode, the block moves the next word into the output register by itself, and output-ready shows that the register holds valid data. A strobe then consumes that word and lets the following one fall through. The almost-empty and almost-full thresholds come from two offset registers that reset loads from parameters. The pointers cross between the domains as Gray code. As a result, a change made on one side reaches the other side's flags exactly two edges of the other clock later. The mode input must stay constant while reset is released.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While rst_n is low, full_n, almost_full_n, empty_n and almost_empty_n are all 0. On the first wr_clk edge after release, full_n and almost_full_n become 1, and empty_n and almost_empty_n stay 0.
- R2: A write is taken when wr_en is 1 at a wr_clk edge while full_n is 1. A wr_en while full_n is 0 stores nothing, so the words read out later are exactly the accepted ones. The fill level never exceeds DEPTH.
- R3: full_n goes to 0 on the wr_clk edge that stores the last free slot. After a read frees a slot, full_n returns to 1 on the second wr_clk edge that follows the read edge.
- R4: In standard mode (fwft_mode = 0), empty_n rises on the second rd_clk edge after the write of the next word. A read accepted while empty_n is 1 places that word on rd_data at that edge. rd_en while empty_n is 0 leaves rd_data unchanged.
- R5: In first-word-fall-through mode (fwft_mode = 1), the next word is loaded into rd_data with no strobe, and empty_n rises on the second rd_clk edge after its write. rd_en while empty_n is 1 consumes that word. With rd_en at 0, rd_data and empty_n hold.
- R6: Words leave in the order they were accepted, under any interleaving of reads and writes.
- R7: almost_empty_n is 0 when the memory holds AE_OFFSET or fewer words and 1 when it holds AE_OFFSET+1 or more. It rises on the second rd_clk edge after the write that crosses the threshold.
- R8: almost_full_n is 0 when the fill level is at least DEPTH-AF_OFFSET and 1 when it is at most DEPTH-AF_OFFSET-1. It rises on the second wr_clk edge after the read that crosses the threshold.
- R9: A word held in the output register is not counted in the fill level used by the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_mode | input | 1 | 0 = standard read port, 1 = first-word-fall-through |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| full_n | output | 1 | Input-ready / not-full, write domain |
| almost_full_n | output | 1 | Low when the fill level reaches the upper threshold |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Output register |
| empty_n | output | 1 | Output-ready / not-empty, read domain |
| almost_empty_n | output | 1 | Low when the memory holds the lower threshold or fewer |

## Verification
The bench ties both clocks to one source, so every synchronization latency becomes an exact cycle count. It compares the outputs against a queue-and-counter model on every cycle. A single isolated write and a single read from a full buffer measure the two-edge rise of empty_n and full_n, separately from their immediate fall. A burst longer than the capacity shows that the surplus writes are dropped and that almost_full_n falls before full_n. Streams with unequal write and read duty cycles exercise ordering while both sides are active. In first-word-fall-through mode, a run that fills the memory to exactly the lower threshold, with a word already in the output register, shows that the held word is excluded from the level.

// File: rtl/fcfifo_pkg.sv
package fcfifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/fcfifo_ptr_sync.sv
module fcfifo_ptr_sync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);

    logic [PW-1:0] cap_d;
    logic [PW-1:0] cap_q;

    always_comb begin
        cap_d = gray_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    for (genvar i = 0; i < PW; i++) begin : g_gray2bin
        assign bin_out[i] = ^cap_q[PW-1:i];
    end

endmodule

// File: rtl/fcfifo_store.sv
module fcfifo_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/fcfifo_wr_side.sv
module fcfifo_wr_side #(
    parameter int ADDR_W    = 4,
    parameter int AF_OFFSET = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W:0]     rptr_sync,
    output logic                wr_fire,
    output logic [ADDR_W-1:0]   waddr,
    output logic [ADDR_W:0]     wgray,
    output logic                full_n,
    output logic                almost_full_n
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [PW-1:0] y_off;
        logic          full_n;
        logic          af_n;
    } wr_state_t;

    wr_state_t     st_d;
    wr_state_t     st_q;
    logic          fire;
    logic [PW-1:0] level;

    always_comb begin
        st_d        = st_q;
        fire        = wr_en & st_q.full_n;
        st_d.ptr    = st_q.ptr + PW'(fire);
        st_d.gray   = st_d.ptr ^ (st_d.ptr >> 1);
        level       = st_d.ptr - rptr_sync;
        st_d.full_n = level < DEPTH_P;
        st_d.af_n   = level < (DEPTH_P - st_q.y_off);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, gray: '0, y_off: PW'(AF_OFFSET),
                      full_n: 1'b0, af_n: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_fire       = fire;
    assign waddr         = st_q.ptr[ADDR_W-1:0];
    assign wgray         = st_q.gray;
    assign full_n        = st_q.full_n;
    assign almost_full_n = st_q.af_n;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ptr - rptr_sync) <= DEPTH_P)
        else $error("write pointer ran ahead of capacity"); // R2

    AST_AF_BEFORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.full_n |-> !st_q.af_n)
        else $error("almost-full high while full"); // R8

endmodule

// File: rtl/fcfifo_rd_side.sv
module fcfifo_rd_side
    import fcfifo_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int AE_OFFSET = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rd_mode_e            mode,
    input  logic                rd_en,
    input  logic [ADDR_W:0]     wptr_sync,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   raddr,
    output logic [ADDR_W:0]     rgray,
    output logic [DATA_W-1:0]   rd_data,
    output logic                empty_n,
    output logic                almost_empty_n
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0]     ptr;
        logic [PW-1:0]     gray;
        logic [PW-1:0]     x_off;
        logic [DATA_W-1:0] data;
        logic              empty_n;
        logic              ae_n;
    } rd_state_t;

    rd_state_t st_d;
    rd_state_t st_q;
    logic      pop;
    logic      avail;
    logic      take;

    always_comb begin
        st_d  = st_q;
        pop   = rd_en & st_q.empty_n;
        avail = wptr_sync != st_q.ptr;
        if (mode == MODE_FWFT) begin
            take = avail & (~st_q.empty_n | pop);
        end else begin
            take = pop;
        end
        st_d.ptr  = st_q.ptr + PW'(take);
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        st_d.data = take ? mem_rdata : st_q.data;
        if (mode == MODE_FWFT) begin
            st_d.empty_n = take | (st_q.empty_n & ~pop);
        end else begin
            st_d.empty_n = wptr_sync != st_d.ptr;
        end
        st_d.ae_n = (wptr_sync - st_d.ptr) > st_q.x_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, gray: '0, x_off: PW'(AE_OFFSET),
                      data: '0, empty_n: 1'b0, ae_n: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr          = st_q.ptr[ADDR_W-1:0];
    assign rgray          = st_q.gray;
    assign rd_data        = st_q.data;
    assign empty_n        = st_q.empty_n;
    assign almost_empty_n = st_q.ae_n;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_sync - st_q.ptr) <= DEPTH_P)
        else $error("read pointer passed write pointer"); // R4

    AST_AE_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ae_n |-> st_q.empty_n)
        else $error("almost-empty high with nothing to read"); // R7

    AST_STD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && !rd_en) |=> $stable(st_q.data))
        else $error("standard-mode output changed without a strobe"); // R4

    AST_FWFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FWFT && st_q.empty_n && !rd_en) |=>
        (st_q.empty_n && $stable(st_q.data)))
        else $error("fall-through word lost without a strobe"); // R5

endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
    import fcfifo_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int AE_OFFSET = 4,
    parameter int AF_OFFSET = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              fwft_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              almost_full_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              almost_empty_n
);

    localparam int PW = ADDR_W + 1;

    logic              wr_fire;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wptr_in_rd;
    logic [PW-1:0]     rptr_in_wr;
    logic [DATA_W-1:0] mem_rdata;
    rd_mode_e          mode;

    assign mode = rd_mode_e'(fwft_mode);

    fcfifo_wr_side #(
        .ADDR_W    (ADDR_W),
        .AF_OFFSET (AF_OFFSET)
    ) u_wr (
        .clk           (wr_clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rptr_sync     (rptr_in_wr),
        .wr_fire       (wr_fire),
        .waddr         (waddr),
        .wgray         (wgray),
        .full_n        (full_n),
        .almost_full_n (almost_full_n)
    );

    fcfifo_ptr_sync #(.PW(PW)) u_rptr_to_wr (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rptr_in_wr)
    );

    fcfifo_ptr_sync #(.PW(PW)) u_wptr_to_rd (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wptr_in_rd)
    );

    fcfifo_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (wr_clk),
        .we    (wr_fire),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    fcfifo_rd_side #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .AE_OFFSET (AE_OFFSET)
    ) u_rd (
        .clk            (rd_clk),
        .rst_n          (rst_n),
        .mode           (mode),
        .rd_en          (rd_en),
        .wptr_sync      (wptr_in_rd),
        .mem_rdata      (mem_rdata),
        .raddr          (raddr),
        .rgray          (rgray),
        .rd_data        (rd_data),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n)
    );

endmodule

// File: tb/tb_dual_clock_flag_fifo.sv
`timescale 1ns/1ps
module tb_dual_clock_flag_fifo;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int XOFF   = 4;
    localparam int YOFF   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              fwft_mode;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              full_n;
    logic              almost_full_n;
    logic              rd_en;
    logic [DATA_W-1:0] rd_data;
    logic              empty_n;
    logic              almost_empty_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_clock_flag_fifo #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .AE_OFFSET (XOFF),
        .AF_OFFSET (YOFF)
    ) dut (
        .wr_clk         (clk),
        .rd_clk         (clk),
        .rst_n          (rst_n),
        .fwft_mode      (fwft_mode),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .full_n         (full_n),
        .almost_full_n  (almost_full_n),
        .rd_en          (rd_en),
        .rd_data        (rd_data),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n)
    );

    // Behavioural reference: a data queue plus running totals of accepted
    // writes and memory reads; each side sees the other's total two edges late.
    logic [DATA_W-1:0] mq[$];
    logic [DATA_W-1:0] m_data;
    logic m_full_n, m_af_n, m_empty_n, m_ae_n;
    int   wtot, rtot, wseen, rseen, wtot_n, rtot_n;
    bit   m_pop, m_take, m_fire;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete();
            m_data = '0;
            m_full_n = 1'b0; m_af_n = 1'b0; m_empty_n = 1'b0; m_ae_n = 1'b0;
            wtot = 0; rtot = 0; wseen = 0; rseen = 0;
        end else begin
            m_pop = rd_en && m_empty_n;
            if (fwft_mode) m_take = (wseen != rtot) && (!m_empty_n || m_pop);
            else           m_take = m_pop;
            rtot_n = rtot;
            if (m_take && mq.size() > 0) begin
                m_data = mq.pop_front();
                rtot_n = rtot + 1;
            end
            m_fire = wr_en && m_full_n;
            wtot_n = wtot;
            if (m_fire) begin
                mq.push_back(wr_data);
                wtot_n = wtot + 1;
            end
            if (fwft_mode) m_empty_n = m_take || (m_empty_n && !m_pop);
            else           m_empty_n = (wseen != rtot_n);
            m_ae_n   = (wseen - rtot_n) > XOFF;
            m_full_n = (wtot_n - rseen) < DEPTH;
            m_af_n   = (wtot_n - rseen) < (DEPTH - YOFF);
            wseen = wtot;
            rseen = rtot;
            wtot  = wtot_n;
            rtot  = rtot_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 full_n vs model", 32'(full_n), 32'(m_full_n));
            chk("R8 almost_full_n vs model", 32'(almost_full_n), 32'(m_af_n));
            chk(fwft_mode ? "R5 empty_n vs model" : "R4 empty_n vs model",
                32'(empty_n), 32'(m_empty_n));
            chk("R7 almost_empty_n vs model", 32'(almost_empty_n), 32'(m_ae_n));
            chk("R6 rd_data vs model", 32'(rd_data), 32'(m_data));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fwft_mode = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        @(negedge clk);
        @(negedge clk);
        // R1: all flags low in reset
        chk("R1 full_n in reset", 32'(full_n), 0);
        chk("R1 almost_full_n in reset", 32'(almost_full_n), 0);
        chk("R1 empty_n in reset", 32'(empty_n), 0);
        chk("R1 almost_empty_n in reset", 32'(almost_empty_n), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 full_n after release", 32'(full_n), 1);
        chk("R1 almost_full_n after release", 32'(almost_full_n), 1);
        chk("R1 empty_n after release", 32'(empty_n), 0);
        chk("R1 almost_empty_n after release", 32'(almost_empty_n), 0);

        // R4: single word latency and ignored reads in standard mode
        wr_en = 1'b1; wr_data = 16'hA5A5;
        tick();
        wr_en = 1'b0;
        chk("R4 empty_n edge+0", 32'(empty_n), 0);
        tick();
        chk("R4 empty_n edge+1", 32'(empty_n), 0);
        tick();
        chk("R4 empty_n edge+2", 32'(empty_n), 1);
        rd_en = 1'b1;
        tick();
        chk("R4 read data", 32'(rd_data), 32'h0000A5A5);
        chk("R4 empty_n after last read", 32'(empty_n), 0);
        tick();
        tick();
        rd_en = 1'b0;
        chk("R4 read while empty ignored", 32'(rd_data), 32'h0000A5A5);

        // R2/R3/R8: overfill, then one read from full
        for (int i = 0; i < 20; i++) begin
            wr_en = 1'b1; wr_data = DATA_W'(16'h1000 + i);
            tick();
        end
        wr_en = 1'b0;
        tick();
        chk("R2 full_n after overfill", 32'(full_n), 0);
        chk("R8 almost_full_n at full", 32'(almost_full_n), 0);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R3 full_n read edge+0", 32'(full_n), 0);
        tick();
        chk("R3 full_n read edge+1", 32'(full_n), 0);
        tick();
        chk("R3 full_n read edge+2", 32'(full_n), 1);
        rd_en = 1'b1;
        for (int i = 0; i < 20; i++) tick();
        rd_en = 1'b0;
        chk("R2 last accepted word", 32'(rd_data), 32'h0000100F);
        chk("R2 drained", 32'(empty_n), 0);

        // R6: concurrent streaming in standard mode
        for (int i = 0; i < 80; i++) begin
            wr_en = (i % 3) != 2; wr_data = DATA_W'(16'h2000 + i);
            rd_en = (i % 4) != 0;
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b1;
        for (int i = 0; i < 30; i++) tick();
        rd_en = 1'b0;

        // switch to first-word-fall-through
        rst_n = 1'b0; fwft_mode = 1'b1;
        tick();
        tick();
        rst_n = 1'b1;
        tick();

        // R5: automatic load of first word
        wr_en = 1'b1; wr_data = 16'h3000;
        tick();
        wr_en = 1'b0;
        chk("R5 ready edge+0", 32'(empty_n), 0);
        tick();
        chk("R5 ready edge+1", 32'(empty_n), 0);
        tick();
        chk("R5 ready edge+2", 32'(empty_n), 1);
        chk("R5 first word falls through", 32'(rd_data), 32'h00003000);

        // R9/R7: held word excluded from level
        for (int i = 1; i <= XOFF; i++) begin
            wr_en = 1'b1; wr_data = DATA_W'(16'h3000 + i);
            tick();
        end
        wr_en = 1'b0;
        tick(); tick(); tick();
        chk("R9 level excludes output word", 32'(almost_empty_n), 0);
        wr_en = 1'b1; wr_data = DATA_W'(16'h3000 + XOFF + 1);
        tick();
        wr_en = 1'b0;
        chk("R7 almost_empty_n edge+0", 32'(almost_empty_n), 0);
        tick();
        chk("R7 almost_empty_n edge+1", 32'(almost_empty_n), 0);
        tick();
        chk("R7 almost_empty_n edge+2", 32'(almost_empty_n), 1);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R5 strobe advances", 32'(rd_data), 32'h00003001);
        chk("R5 still ready", 32'(empty_n), 1);

        // fill to full in FWFT, then drain with gaps
        for (int i = 0; i < 30; i++) begin
            wr_en = 1'b1; wr_data = DATA_W'(16'h4000 + i);
            tick();
        end
        wr_en = 1'b0;
        chk("R3 input-ready low when full", 32'(full_n), 0);
        for (int i = 0; i < 60; i++) begin
            rd_en = (i % 2) == 0;
            tick();
        end
        rd_en = 1'b0;

        // R6: concurrent streaming in FWFT mode
        for (int i = 0; i < 90; i++) begin
            wr_en = (i % 2 == 0) || (i % 5 == 0); wr_data = DATA_W'(16'h5000 + i);
            rd_en = (i % 3) == 0;
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b1;
        for (int i = 0; i < 40; i++) tick();
        rd_en = 1'b0;
        tick();
        chk("R6 all words delivered", 32'(empty_n), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule